// File: doc/BRIEF.md
# Register File with Paired Write

This block is the general-purpose register file of a pipelined integer core: 32 registers of 32 bits, two combinational read ports and a single write port. The write port either updates one register, or, for a widening multiply, updates two neighbouring registers in one cycle. In a pair write, the low half of a 64-bit result goes to the addressed register and the high half goes to the next register number.

Register zero is a constant zero. Write-back lands early in the cycle and operand reads happen late in the cycle. A read of a register that is being written in the current cycle therefore returns the incoming value, not the stored one.

The multiplier, pipeline control and hazard detection sit outside this block.

Top module: `pairwr_regfile`

## Requirements
- R1: A synchronous active-high reset clears every register, so all reads return zero after it.
- R2: A single write (`wr_en`=1, `wr_pair`=0) stores `wr_data[31:0]` in register `wr_addr`. Later reads of that register return it until it is written again.
- R3: Register 0 always reads as zero on both ports. Any write aimed at it has no effect.
- R4: During a single write, a read of `wr_addr` in the same cycle returns `wr_data[31:0]`.
- R5: A pair write (`wr_en`=1, `wr_pair`=1) stores `wr_data[31:0]` in register `wr_addr` and `wr_data[63:32]` in register `wr_addr`+1. No other register changes.
- R6: During a pair write, same-cycle reads of `wr_addr` and `wr_addr`+1 return the low and high halves respectively.
- R7: A pair write with `wr_addr`=31 stores the low half in register 31 and discards the high half. The high half does not wrap to register 0 or register 1.
- R8: A pair write with `wr_addr`=0 drops the low half and still stores the high half in register 1.
- R9: While `wr_en` is 0, `wr_pair`, `wr_addr` and `wr_data` have no effect on any register.
- R10: A single write ignores `wr_data[63:32]` and leaves register `wr_addr`+1 unchanged.
- R11: The two read ports are independent. Each returns the register selected by its own address in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rd_addr_a | input | 5 | Read address, port A |
| rd_data_a | output | 32 | Read data, port A (combinational) |
| rd_addr_b | input | 5 | Read address, port B |
| rd_data_b | output | 32 | Read data, port B (combinational) |
| wr_en | input | 1 | Write enable |
| wr_pair | input | 1 | 1 = pair write to wr_addr and wr_addr+1 |
| wr_addr | input | 5 | Write address |
| wr_data | input | 64 | Write data; the low half goes to wr_addr, the high half to wr_addr+1 on a pair write |

## Verification
The bench builds the block with its default parameters: 32 registers of 32 bits. With these values both ends of the address range can be driven. Register 31 exposes the discarded high half and any 5-bit wrap to registers 0 or 1. Register 0 exposes the dropped low half of a pair write. Each stimulus cycle checks both the same-cycle bypass value and, one cycle later, the stored value.

// File: rtl/pairwr_regfile_pkg.sv
package pairwr_regfile_pkg;

    localparam int unsigned NREGS_DEF = 32;
    localparam int unsigned XLEN_DEF  = 32;

    // Which half of the write word a register slot takes this cycle
    typedef enum logic {
        HALF_LO = 1'b0,
        HALF_HI = 1'b1
    } half_e;

    // Per-register write selection produced by the decoder
    typedef struct packed {
        logic  hit;
        half_e half;
    } slot_sel_t;

    // True when register rd+1 exists in a file of nregs entries
    function automatic logic upper_exists(input int unsigned rd, input int unsigned nregs);
        return (rd + 1) < nregs;
    endfunction

endpackage

// File: rtl/pairwr_wr_decode.sv
module pairwr_wr_decode
    import pairwr_regfile_pkg::*;
#(
    parameter int unsigned NREGS = NREGS_DEF,
    localparam int unsigned AW   = $clog2(NREGS)
) (
    input  logic                        wr_en,
    input  logic                        wr_pair,
    input  logic [AW-1:0]               wr_addr,
    output slot_sel_t [NREGS-1:0]       sel
);

    for (genvar g = 0; g < NREGS; g++) begin : g_slot
        if (g == 0) begin : g_zero
            // register zero never accepts a write
            assign sel[g] = '{hit: 1'b0, half: HALF_LO};
        end else begin : g_live
            always_comb begin
                sel[g] = '{hit: 1'b0, half: HALF_LO};
                if (wr_en) begin
                    if (wr_addr == AW'(g)) begin
                        sel[g] = '{hit: 1'b1, half: HALF_LO};
                    end else if (wr_pair && wr_addr == AW'(g - 1)
                                 && upper_exists(g - 1, NREGS)) begin
                        sel[g] = '{hit: 1'b1, half: HALF_HI};
                    end
                end
            end
        end
    end

endmodule

// File: rtl/pairwr_store.sv
module pairwr_store
    import pairwr_regfile_pkg::*;
#(
    parameter int unsigned NREGS = NREGS_DEF,
    parameter int unsigned XLEN  = XLEN_DEF
) (
    input  logic                  clk,
    input  logic                  rst,
    input  slot_sel_t [NREGS-1:0] sel,
    input  logic [XLEN-1:0]       wlo,
    input  logic [XLEN-1:0]       whi,
    output logic [XLEN-1:0]       q [NREGS]
);

    for (genvar g = 0; g < NREGS; g++) begin : g_reg
        if (g == 0) begin : g_const
            assign q[g] = '0;
        end else begin : g_flop
            logic [XLEN-1:0] val;
            always_ff @(posedge clk) begin
                if (rst) begin
                    val <= '0;
                end else if (sel[g].hit) begin
                    val <= (sel[g].half == HALF_HI) ? whi : wlo;
                end
            end
            assign q[g] = val;
        end
    end

endmodule

// File: rtl/pairwr_rd_port.sv
module pairwr_rd_port
    import pairwr_regfile_pkg::*;
#(
    parameter int unsigned NREGS = NREGS_DEF,
    parameter int unsigned XLEN  = XLEN_DEF,
    localparam int unsigned AW   = $clog2(NREGS)
) (
    input  logic [AW-1:0]         raddr,
    input  slot_sel_t [NREGS-1:0] sel,
    input  logic [XLEN-1:0]       wlo,
    input  logic [XLEN-1:0]       whi,
    input  logic [XLEN-1:0]       q [NREGS],
    output logic [XLEN-1:0]       rdata
);

    slot_sel_t s;

    always_comb begin
        s = sel[raddr];
        if (raddr == '0) begin
            rdata = '0;
        end else if (s.hit) begin
            // same-cycle forward of the value being written
            rdata = (s.half == HALF_HI) ? whi : wlo;
        end else begin
            rdata = q[raddr];
        end
    end

endmodule

// File: rtl/pairwr_regfile.sv
module pairwr_regfile
    import pairwr_regfile_pkg::*;
#(
    parameter int unsigned NREGS = NREGS_DEF,
    parameter int unsigned XLEN  = XLEN_DEF,
    localparam int unsigned AW   = $clog2(NREGS),
    localparam int unsigned WW   = 2 * XLEN
) (
    input  logic            clk,
    input  logic            rst,
    input  logic [AW-1:0]   rd_addr_a,
    output logic [XLEN-1:0] rd_data_a,
    input  logic [AW-1:0]   rd_addr_b,
    output logic [XLEN-1:0] rd_data_b,
    input  logic            wr_en,
    input  logic            wr_pair,
    input  logic [AW-1:0]   wr_addr,
    input  logic [WW-1:0]   wr_data
);

    localparam int unsigned NPORTS = 2;

    slot_sel_t [NREGS-1:0] sel;
    logic [XLEN-1:0]       q [NREGS];
    logic [XLEN-1:0]       wlo, whi;
    logic [AW-1:0]         ra [NPORTS];
    logic [XLEN-1:0]       rd [NPORTS];

    assign wlo = wr_data[XLEN-1:0];
    assign whi = wr_data[WW-1:XLEN];

    pairwr_wr_decode #(.NREGS(NREGS)) u_dec (
        .wr_en  (wr_en),
        .wr_pair(wr_pair),
        .wr_addr(wr_addr),
        .sel    (sel)
    );

    pairwr_store #(.NREGS(NREGS), .XLEN(XLEN)) u_store (
        .clk(clk),
        .rst(rst),
        .sel(sel),
        .wlo(wlo),
        .whi(whi),
        .q  (q)
    );

    assign ra[0]     = rd_addr_a;
    assign ra[1]     = rd_addr_b;
    assign rd_data_a = rd[0];
    assign rd_data_b = rd[1];

    for (genvar p = 0; p < NPORTS; p++) begin : g_port
        pairwr_rd_port #(.NREGS(NREGS), .XLEN(XLEN)) u_rd (
            .raddr(ra[p]),
            .sel  (sel),
            .wlo  (wlo),
            .whi  (whi),
            .q    (q),
            .rdata(rd[p])
        );
    end

endmodule

// File: rtl/pairwr_regfile_chk.sv
module pairwr_regfile_chk #(
    parameter int unsigned NREGS = 32,
    parameter int unsigned XLEN  = 32,
    localparam int unsigned AW   = $clog2(NREGS),
    localparam int unsigned WW   = 2 * XLEN
) (
    input logic            clk,
    input logic            rst,
    input logic [AW-1:0]   rd_addr_a,
    input logic [XLEN-1:0] rd_data_a,
    input logic [AW-1:0]   rd_addr_b,
    input logic [XLEN-1:0] rd_data_b,
    input logic            wr_en,
    input logic            wr_pair,
    input logic [AW-1:0]   wr_addr,
    input logic [WW-1:0]   wr_data
);

    localparam logic [AW-1:0] TOP = AW'(NREGS - 1);

    // R3
    zero_reg_a_chk: assert property (@(posedge clk) disable iff (rst)
        rd_addr_a == '0 |-> rd_data_a == '0);

    // R3
    zero_reg_b_chk: assert property (@(posedge clk) disable iff (rst)
        rd_addr_b == '0 |-> rd_data_b == '0);

    // R4
    single_fwd_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_en && !wr_pair && wr_addr != '0 && rd_addr_a == wr_addr)
        |-> rd_data_a == wr_data[XLEN-1:0]);

    // R6
    pair_hi_fwd_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_pair && wr_addr != TOP && rd_addr_b == wr_addr + AW'(1))
        |-> rd_data_b == wr_data[WW-1:XLEN]);

    // R8
    pair_at_zero_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_pair && wr_addr == '0 && rd_addr_b == AW'(1))
        |-> rd_data_b == wr_data[WW-1:XLEN]);

    // R9
    idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!wr_en && $past(!wr_en) && $past(!rst) && rd_addr_a == $past(rd_addr_a))
        |-> rd_data_a == $past(rd_data_a));

endmodule

bind pairwr_regfile pairwr_regfile_chk #(.NREGS(NREGS), .XLEN(XLEN)) u_chk (.*);

// File: tb/pairwr_regfile_bench.sv
module pairwr_regfile_bench;

    typedef struct {
        logic [31:0] e_a;
        logic [31:0] e_b;
        string       tag;
    } exp_t;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [4:0]  rd_addr_a = '0, rd_addr_b = '0, wr_addr = '0;
    logic [31:0] rd_data_a, rd_data_b;
    logic        wr_en = 1'b0, wr_pair = 1'b0;
    logic [63:0] wr_data = '0;

    int   n_chk  = 0;
    int   n_fail = 0;
    bit   done   = 1'b0;
    exp_t exp_q [$];

    always #2.5 clk = ~clk;

    pairwr_regfile u_pairwr_regfile (
        .clk(clk), .rst(rst),
        .rd_addr_a(rd_addr_a), .rd_data_a(rd_data_a),
        .rd_addr_b(rd_addr_b), .rd_data_b(rd_data_b),
        .wr_en(wr_en), .wr_pair(wr_pair), .wr_addr(wr_addr), .wr_data(wr_data)
    );

    // driver: one stimulus cycle, expected read data pushed to the scoreboard
    task automatic step(input logic we, input logic pr, input logic [4:0] wa,
                        input logic [63:0] wd, input logic [4:0] ra, input logic [4:0] rb,
                        input logic [31:0] ea, input logic [31:0] eb, input string tag);
        @(posedge clk);
        #1;
        wr_en = we; wr_pair = pr; wr_addr = wa; wr_data = wd;
        rd_addr_a = ra; rd_addr_b = rb;
        exp_q.push_back('{e_a: ea, e_b: eb, tag: tag});
    endtask

    task automatic idle_read(input logic [4:0] ra, input logic [4:0] rb,
                             input logic [31:0] ea, input logic [31:0] eb, input string tag);
        step(1'b0, 1'b0, 5'd0, 64'd0, ra, rb, ea, eb, tag);
    endtask

    // monitor: compare outputs mid-cycle
    always @(negedge clk) begin
        if (exp_q.size() > 0) begin
            exp_t it;
            it = exp_q.pop_front();
            n_chk++;
            if (rd_data_a !== it.e_a) begin
                n_fail++;
                $display("FAIL %s port A: got %h expected %h", it.tag, rd_data_a, it.e_a);
            end
            n_chk++;
            if (rd_data_b !== it.e_b) begin
                n_fail++;
                $display("FAIL %s port B: got %h expected %h", it.tag, rd_data_b, it.e_b);
            end
        end
    end

    task automatic finish_run();
        done = 1'b1;
        $display("  %0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    endtask

    initial begin
        #100000;
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            finish_run();
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;
        // R1 reset state
        idle_read(5'd5, 5'd31, 32'h0, 32'h0, "R1 after reset");
        // R4 bypass, R10 upper half ignored on single write
        step(1'b1, 1'b0, 5'd5, 64'hDEADBEEF_A5A50001, 5'd5, 5'd6,
             32'hA5A50001, 32'h0, "R4 R10 single write");
        idle_read(5'd5, 5'd6, 32'hA5A50001, 32'h0, "R2 R10 stored");
        // R3 register zero
        step(1'b1, 1'b0, 5'd0, 64'h0000_0000_0000_1234, 5'd0, 5'd0, 32'h0, 32'h0, "R3 write r0");
        idle_read(5'd0, 5'd0, 32'h0, 32'h0, "R3 r0 after write");
        // R6 pair bypass, R5 stored
        step(1'b1, 1'b1, 5'd10, 64'h11112222_33334444, 5'd10, 5'd11,
             32'h33334444, 32'h11112222, "R6 pair bypass");
        idle_read(5'd10, 5'd11, 32'h33334444, 32'h11112222, "R5 pair stored");
        idle_read(5'd9, 5'd12, 32'h0, 32'h0, "R5 neighbours untouched");
        // R7 pair at top
        step(1'b1, 1'b1, 5'd31, 64'hFFFF0000_0000BEEF, 5'd31, 5'd0,
             32'h0000BEEF, 32'h0, "R7 pair at r31 bypass");
        idle_read(5'd31, 5'd1, 32'h0000BEEF, 32'h0, "R7 no wrap");
        // R8 pair at zero
        step(1'b1, 1'b1, 5'd0, 64'h77770001_00009999, 5'd0, 5'd1,
             32'h0, 32'h77770001, "R8 pair at r0 bypass");
        idle_read(5'd0, 5'd1, 32'h0, 32'h77770001, "R8 stored");
        // R9 disabled write ignored
        step(1'b0, 1'b1, 5'd5, 64'h12345678_9ABCDEF0, 5'd5, 5'd6,
             32'hA5A50001, 32'h0, "R9 we low");
        idle_read(5'd5, 5'd6, 32'hA5A50001, 32'h0, "R9 after we low");
        // R11 independent ports
        idle_read(5'd10, 5'd5, 32'h33334444, 32'hA5A50001, "R11 ports");
        idle_read(5'd5, 5'd10, 32'hA5A50001, 32'h33334444, "R11 swapped");
        step(1'b1, 1'b0, 5'd11, 64'hAAAAAAAA_00005555, 5'd10, 5'd11,
             32'h33334444, 32'h00005555, "R11 R4 overwrite");
        idle_read(5'd11, 5'd12, 32'h00005555, 32'h0, "R2 R10 overwrite stored");
        // R1 reset mid-run
        @(posedge clk);
        #1 rst = 1'b1; wr_en = 1'b0;
        @(posedge clk);
        #1 rst = 1'b0;
        idle_read(5'd5, 5'd31, 32'h0, 32'h0, "R1 reset clears");
        idle_read(5'd1, 5'd11, 32'h0, 32'h0, "R1 reset clears");
        @(posedge clk);
        @(posedge clk);
        finish_run();
    end

endmodule